// File: doc/BRIEF.md
# Page-Table Refill Sequencer for TLB Misses

This block runs the hardware refill that follows a TLB miss. It accepts one missing virtual address at a time, then forms the virtual address of the matching page-table word. The linear page table lives in virtual space, so it sends that address to the external TLB as a ring-0 load probe. The probe may not start a refill of its own. On a hit it reads the 32-bit page-table word from memory and writes it into one of the four refillable ways. The sequencer then reports success together with the ring held in the word.

If the probe misses or the memory read returns an error, nothing is written and the requester gets back the miss cause it started from. The TLB array and its lookup logic sit outside this block. The sequencer reaches them through a lookup port and a write port.

The miss input, the lookup request and the memory request each use valid/ready. A request holds valid and keeps its address stable until ready is seen, so the responder can stall it for any number of cycles. The memory response arrives as a valid pulse and is taken only while the sequencer shows response-ready. The page-table base input must stay stable while the block is busy.

Top module: `tlb_refill_ctrl`

## Requirements
- R1: After reset, busy and done are low, miss_ready is high, excvaddr is zero and the round-robin counter is zero.
- R2: The lookup address is (pt_base OR (faulting address >> 10)) with its two low bits forced to zero.
- R3: A lookup miss ends the refill with done_ok low and done_cause set to the original miss cause: 16 for an instruction fetch (miss_fetch=1), 24 for a data access. No memory request and no TLB write take place.
- R4: A memory response with the error flag set ends the refill with done_ok low, the original miss cause and no TLB write.
- R5: A good memory response drives wr_en for exactly that cycle. In that cycle wr_vpn is address bits 31:12, wr_index is address bits 13:12, and wr_pte is the fetched word. In the next cycle done is high with done_ok set and done_cause 0.
- R6: The write way comes from a pre-incremented counter: successive successful refills use ways 1, 2, 3, 0, 1 and so on. A failed refill does not advance the counter.
- R7: On a successful refill excvaddr takes the faulting address, visible in the done cycle. A failed refill leaves it unchanged.
- R8: On success done_ring carries bits 5:4 of the fetched word.
- R9: busy rises in the cycle after a miss is accepted and stays high through the single done cycle. miss_ready is low during that whole time, and done is never high for two cycles in a row.
- R10: A lookup or memory request that is not yet accepted holds valid and keeps its address unchanged in the next cycle.
- R11: The memory read address is the physical address returned with the lookup hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 32 | Page-table base register value |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Sequencer can accept a miss |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_fetch | input | 1 | 1: instruction fetch miss, 0: data miss |
| busy | output | 1 | Refill in progress |
| lk_valid | output | 1 | Lookup request valid |
| lk_ready | input | 1 | Lookup result present this cycle |
| lk_vaddr | output | 32 | Page-table word virtual address |
| lk_hit | input | 1 | Lookup hit with ring-0 load permission |
| lk_paddr | input | 32 | Translated physical address |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 32 | Memory read address |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Sequencer waiting for response |
| mem_rsp_err | input | 1 | Memory response error |
| mem_rsp_data | input | 32 | Fetched page-table word |
| wr_en | output | 1 | TLB write strobe |
| wr_way | output | 2 | Refill way |
| wr_index | output | 2 | Entry index within the way |
| wr_vpn | output | 20 | Virtual page number for the entry |
| wr_pte | output | 32 | Page-table word to install |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Refill succeeded |
| done_cause | output | 6 | 0 on success, else the miss cause |
| done_ring | output | 2 | Ring from the page-table word on success |
| excvaddr | output | 32 | Fault virtual-address register |

## Verification
Two events can land in the same cycle: the done pulse of one refill and a new miss request that is already valid. The bench raises miss_valid for a second address during the done cycle. It then checks that miss_ready is low there, that busy drops in the following cycle without the request being taken, and that the miss is accepted one edge later. The second refill must write the next way in the rotation. A successful TLB write also happens in the same cycle as the load of excvaddr. The bench checks the written way, index and word in that cycle and the new excvaddr in the done cycle that follows.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LOOK = 3'd1,
    S_MREQ = 3'd2,
    S_MRSP = 3'd3,
    S_DONE = 3'd4
  } tlbr_state_e;
endpackage

// File: rtl/tlbr_addr_gen.sv
module tlbr_addr_gen #(
  parameter int VA_W       = 32,
  parameter int PT_SHIFT   = 10,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 2
) (
  input  logic [VA_W-1:0]            fault_va,
  input  logic [VA_W-1:0]            base,
  output logic [VA_W-1:0]            pte_va,
  output logic [VA_W-PAGE_SHIFT-1:0] vpn,
  output logic [IDX_W-1:0]           index
);
  localparam logic [VA_W-1:0] WORD_MASK = VA_W'(3);

  // word-aligned pointer into the virtually mapped linear table
  assign pte_va = (base | (fault_va >> PT_SHIFT)) & ~WORD_MASK;
  assign vpn    = fault_va[VA_W-1:PAGE_SHIFT];
  assign index  = fault_va[PAGE_SHIFT +: IDX_W];
endmodule

// File: rtl/tlbr_way_rr.sv
module tlbr_way_rr #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WAY_W-1:0] way_next
);
  logic [WAY_W-1:0] cnt_q;

  // pre-increment: the way used is the counter value after the step
  assign way_next = cnt_q + WAY_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (adv) cnt_q <= way_next;
  end

  assert_way_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cnt_q == $past(cnt_q) + WAY_W'(1));
  assert_way_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q));
endmodule

// File: rtl/tlbr_seq.sv
module tlbr_seq
  import tlbr_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int DATA_W   = 32,
  parameter int RING_LSB = 4,
  parameter int CAUSE_W  = 6,
  parameter logic [CAUSE_W-1:0] CAUSE_IMISS = 6'd16,
  parameter logic [CAUSE_W-1:0] CAUSE_DMISS = 6'd24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VA_W-1:0]    miss_vaddr,
  input  logic               miss_fetch,
  output logic               busy,
  output logic [VA_W-1:0]    cur_va,
  output logic               lk_valid,
  input  logic               lk_ready,
  input  logic               lk_hit,
  input  logic [VA_W-1:0]    lk_paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [VA_W-1:0]    mem_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic               mem_rsp_err,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  output logic               wr_en,
  output logic               done,
  output logic               done_ok,
  output logic [CAUSE_W-1:0] done_cause,
  output logic [1:0]         done_ring,
  output logic [VA_W-1:0]    excvaddr
);
  tlbr_state_e      st_q;
  logic [VA_W-1:0]  va_q, pa_q, excv_q;
  logic             fetch_q, ok_q;
  logic [1:0]       ring_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      va_q    <= '0;
      pa_q    <= '0;
      excv_q  <= '0;
      fetch_q <= 1'b0;
      ok_q    <= 1'b0;
      ring_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (miss_valid) begin
          va_q    <= miss_vaddr;
          fetch_q <= miss_fetch;
          st_q    <= S_LOOK;
        end
        S_LOOK: if (lk_ready) begin
          if (lk_hit) begin
            pa_q <= lk_paddr;
            st_q <= S_MREQ;
          end else begin
            ok_q <= 1'b0;
            st_q <= S_DONE;
          end
        end
        S_MREQ: if (mem_req_ready) st_q <= S_MRSP;
        S_MRSP: if (mem_rsp_valid) begin
          ok_q <= !mem_rsp_err;
          if (!mem_rsp_err) begin
            ring_q <= mem_rsp_data[RING_LSB +: 2];
            excv_q <= va_q;
          end
          st_q <= S_DONE;
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign miss_ready    = (st_q == S_IDLE);
  assign busy          = (st_q != S_IDLE);
  assign cur_va        = va_q;
  assign lk_valid      = (st_q == S_LOOK);
  assign mem_req_valid = (st_q == S_MREQ);
  assign mem_addr      = pa_q;
  assign mem_rsp_ready = (st_q == S_MRSP);
  assign wr_en         = (st_q == S_MRSP) && mem_rsp_valid && !mem_rsp_err;
  assign done          = (st_q == S_DONE);
  assign done_ok       = done && ok_q;
  assign done_cause    = done_ok ? '0 : (fetch_q ? CAUSE_IMISS : CAUSE_DMISS);
  assign done_ring     = done_ok ? ring_q : 2'b00;
  assign excvaddr      = excv_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (busy && !miss_ready));
  assert_write_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (done && done_ok && done_cause == '0));
  assert_excv_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> excvaddr == $past(cur_va));
  assert_fail_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ok) |-> (done_cause == CAUSE_IMISS || done_cause == CAUSE_DMISS));
  assert_miss_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !lk_hit) |=> (!mem_req_valid && !wr_en));
  assert_err_keep_excv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_ready && mem_rsp_valid && mem_rsp_err) |=> $stable(excvaddr));
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
  assert_mem_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && lk_hit) |=> mem_addr == $past(lk_paddr));
endmodule

// File: rtl/tlb_refill_ctrl.sv
module tlb_refill_ctrl #(
  parameter int VA_W           = 32,
  parameter int DATA_W         = 32,
  parameter int PAGE_SHIFT     = 12,
  parameter int PT_SHIFT       = 10,
  parameter int REFILL_WAYS    = 4,
  parameter int REFILL_ENTRIES = 4,
  parameter int RING_LSB       = 4,
  parameter int CAUSE_W        = 6,
  parameter logic [CAUSE_W-1:0] CAUSE_IMISS = 6'd16,
  parameter logic [CAUSE_W-1:0] CAUSE_DMISS = 6'd24,
  localparam int WAY_W = $clog2(REFILL_WAYS),
  localparam int IDX_W = $clog2(REFILL_ENTRIES),
  localparam int VPN_W = VA_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VA_W-1:0]    pt_base,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VA_W-1:0]    miss_vaddr,
  input  logic               miss_fetch,
  output logic               busy,
  output logic               lk_valid,
  input  logic               lk_ready,
  output logic [VA_W-1:0]    lk_vaddr,
  input  logic               lk_hit,
  input  logic [VA_W-1:0]    lk_paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [VA_W-1:0]    mem_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic               mem_rsp_err,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  output logic               wr_en,
  output logic [WAY_W-1:0]   wr_way,
  output logic [IDX_W-1:0]   wr_index,
  output logic [VPN_W-1:0]   wr_vpn,
  output logic [DATA_W-1:0]  wr_pte,
  output logic               done,
  output logic               done_ok,
  output logic [CAUSE_W-1:0] done_cause,
  output logic [1:0]         done_ring,
  output logic [VA_W-1:0]    excvaddr
);
  logic [VA_W-1:0] cur_va;

  tlbr_seq #(
    .VA_W(VA_W), .DATA_W(DATA_W), .RING_LSB(RING_LSB), .CAUSE_W(CAUSE_W),
    .CAUSE_IMISS(CAUSE_IMISS), .CAUSE_DMISS(CAUSE_DMISS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_vaddr(miss_vaddr), .miss_fetch(miss_fetch),
    .busy(busy), .cur_va(cur_va),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .wr_en(wr_en), .done(done), .done_ok(done_ok), .done_cause(done_cause),
    .done_ring(done_ring), .excvaddr(excvaddr)
  );

  tlbr_addr_gen #(
    .VA_W(VA_W), .PT_SHIFT(PT_SHIFT), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)
  ) u_addr (
    .fault_va(cur_va), .base(pt_base),
    .pte_va(lk_vaddr), .vpn(wr_vpn), .index(wr_index)
  );

  tlbr_way_rr #(.WAYS(REFILL_WAYS)) u_way (
    .clk(clk), .rst_n(rst_n), .adv(wr_en), .way_next(wr_way)
  );

  assign wr_pte = mem_rsp_data;

  assert_lk_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_vaddr)));
  assert_lk_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> lk_vaddr[1:0] == 2'b00);
endmodule

// File: tb/sim_tlb_refill_ctrl.sv
module sim_tlb_refill_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        fetch;
    logic [31:0] vaddr;
    logic [31:0] ptbase;
    logic        hit;
    logic [31:0] paddr;
    logic        err;
    logic [31:0] pte;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0040_3123, 32'h8000_0000, 1'b1, 32'h1000_2008, 1'b0, 32'h1234_5027},
    '{1'b1, 32'h7FFF_F004, 32'hC000_0000, 1'b1, 32'h2000_0FFC, 1'b0, 32'hABCD_E03F},
    '{1'b0, 32'h1234_5678, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b0, 32'h0000_0000},
    '{1'b1, 32'h0000_2ABC, 32'h4000_0000, 1'b1, 32'h3000_0010, 1'b1, 32'hFFFF_FFFF},
    '{1'b0, 32'hFFFF_3FFF, 32'h0040_0000, 1'b1, 32'h0BAD_0004, 1'b0, 32'h0055_5013},
    '{1'b1, 32'h8001_1000, 32'hE000_0000, 1'b1, 32'h0000_0100, 1'b0, 32'h7654_3007},
    '{1'b0, 32'h0000_0FFF, 32'h9000_0000, 1'b1, 32'h4444_4440, 1'b0, 32'h0F0F_0F2A},
    '{1'b1, 32'hDEAD_BEEF, 32'hA000_0000, 1'b0, 32'h0000_0000, 1'b0, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pt_base = '0, miss_vaddr = '0, lk_paddr = '0, mem_rsp_data = '0;
  logic miss_valid = 1'b0, miss_fetch = 1'b0, lk_ready = 1'b0, lk_hit = 1'b0;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic miss_ready, busy, lk_valid, mem_req_valid, mem_rsp_ready, wr_en;
  logic done, done_ok;
  logic [31:0] lk_vaddr, mem_addr, wr_pte, excvaddr;
  logic [1:0]  wr_way, wr_index, done_ring;
  logic [19:0] wr_vpn;
  logic [5:0]  done_cause;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int model_cnt = 0;
  logic [31:0] model_excv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_refill_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vaddr(miss_vaddr),
    .miss_fetch(miss_fetch), .busy(busy),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .wr_en(wr_en), .wr_way(wr_way), .wr_index(wr_index), .wr_vpn(wr_vpn),
    .wr_pte(wr_pte), .done(done), .done_ok(done_ok), .done_cause(done_cause),
    .done_ring(done_ring), .excvaddr(excvaddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_miss(input vec_t v, input bit hold_next,
                          input logic [31:0] nxt_va, input logic nxt_fetch);
    logic [31:0] exp_pva;
    logic [31:0] held;
    bit ok;
    logic [5:0] exp_cause;
    exp_pva   = (v.ptbase | (v.vaddr >> 10)) & 32'hFFFF_FFFC;
    ok        = v.hit && !v.err;
    exp_cause = ok ? 6'd0 : (v.fetch ? 6'd16 : 6'd24);
    pt_base    = v.ptbase;
    miss_valid = 1'b1;
    miss_vaddr = v.vaddr;
    miss_fetch = v.fetch;
    step();
    miss_valid = 1'b0;
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    chk("R9 miss_ready low", {31'd0, miss_ready}, 32'd0);
    chk("R2 lookup valid", {31'd0, lk_valid}, 32'd1);
    chk("R2 lookup address", lk_vaddr, exp_pva);
    held = lk_vaddr;
    step();
    chk("R10 lookup held", {31'd0, lk_valid}, 32'd1);
    chk("R10 lookup addr stable", lk_vaddr, held);
    lk_ready = 1'b1; lk_hit = v.hit; lk_paddr = v.paddr;
    step();
    lk_ready = 1'b0; lk_hit = 1'b0;
    if (v.hit) begin
      chk("R11 mem request", {31'd0, mem_req_valid}, 32'd1);
      chk("R11 mem address", mem_addr, v.paddr);
      step();
      chk("R10 mem addr stable", mem_addr, v.paddr);
      mem_req_ready = 1'b1;
      step();
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_err = v.err; mem_rsp_data = v.pte;
      #1;
      chk(ok ? "R5 write strobe" : "R4 no write on error", {31'd0, wr_en}, {31'd0, ok});
      if (ok) begin
        model_cnt = (model_cnt + 1) % 4;
        chk("R6 way", {30'd0, wr_way}, model_cnt);
        chk("R5 index", {30'd0, wr_index}, {30'd0, v.vaddr[13:12]});
        chk("R5 vpn", {12'd0, wr_vpn}, {12'd0, v.vaddr[31:12]});
        chk("R5 pte", wr_pte, v.pte);
      end
      step();
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    end else begin
      chk("R3 no mem request", {31'd0, mem_req_valid}, 32'd0);
      chk("R3 no write", {31'd0, wr_en}, 32'd0);
    end
    if (ok) model_excv = v.vaddr;
    chk("R9 done", {31'd0, done}, 32'd1);
    chk(ok ? "R5 done_ok" : "R3/R4 done_ok", {31'd0, done_ok}, {31'd0, ok});
    chk(v.hit ? "R4 cause" : "R3 cause", {26'd0, done_cause}, {26'd0, exp_cause});
    chk("R7 excvaddr", excvaddr, model_excv);
    if (ok) chk("R8 ring", {30'd0, done_ring}, {30'd0, v.pte[5:4]});
    if (hold_next) begin
      miss_valid = 1'b1; miss_vaddr = nxt_va; miss_fetch = nxt_fetch;
      chk("R9 not ready in done cycle", {31'd0, miss_ready}, 32'd0);
    end
    step();
    chk("R9 done single cycle", {31'd0, done}, 32'd0);
    chk("R9 idle after done", {31'd0, busy}, 32'd0);
    chk("R9 ready again", {31'd0, miss_ready}, 32'd1);
    if (hold_next) chk("R9 held miss not yet taken", {31'd0, lk_valid}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t extra;
    @(negedge clk);
    @(negedge clk);
    chk("R1 busy reset", {31'd0, busy}, 32'd0);
    chk("R1 done reset", {31'd0, done}, 32'd0);
    chk("R1 ready reset", {31'd0, miss_ready}, 32'd1);
    chk("R1 excvaddr reset", excvaddr, 32'd0);
    rst_n = 1'b1;
    step();
    for (int i = 0; i < NVEC; i++) begin
      run_miss(VECS[i], 1'b0, 32'd0, 1'b0);
    end
    // R6: a failure after these must not advance the counter; R9: back-to-back
    extra = '{1'b0, 32'h5555_5000, 32'h8800_0000, 1'b1, 32'h0123_4560, 1'b0, 32'h0000_0020};
    run_miss(extra, 1'b1, 32'h6666_6000, 1'b1);
    extra = '{1'b1, 32'h6666_6000, 32'h8800_0000, 1'b1, 32'h0765_4320, 1'b0, 32'h0000_0010};
    run_miss(extra, 1'b0, 32'd0, 1'b0);
    // R1: reset clears the counter, so the next refill uses way 1 again
    rst_n = 1'b0;
    step();
    chk("R1 excvaddr cleared", excvaddr, 32'd0);
    rst_n = 1'b1;
    model_cnt = 0;
    model_excv = '0;
    step();
    run_miss(VECS[0], 1'b0, 32'd0, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule